// File: doc/BRIEF.md
# SD Card SPI Command Engine

This block runs one complete command exchange with an SD card in SPI mode. A requester hands it a 6-bit command index and a 32-bit argument. The engine drops chip select and sends the 6-byte command frame through a byte-wide SPI master. It then clocks out fill bytes until the card answers with a status byte whose top bit is clear. For the two commands whose answer is longer, it also gathers the four bytes that follow the status byte. It then releases chip select and sends one more fill byte, so the card lets go of its data line. A hold option leaves chip select low after the answer, so that a data-phase block can take over the bus.

The request and response sides are valid/ready streams. A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is high only while the engine is idle. The result is presented with `rsp_valid` and stays there, unchanged, until `rsp_ready` takes it. Downstream, every byte is offered on `spi_tx_valid`/`spi_tx_ready`, and the SPI master may stall that offer for any number of cycles. For each accepted byte, the master returns exactly one received byte as a one-cycle `spi_rx_valid` pulse. The engine waits for that pulse before it offers the next byte.

Top module: `sdcmd_engine`

## Requirements
- R1: `req_ready` is high only in the idle state. `busy` rises the cycle after a request is accepted and stays high until the response handshake completes. No request is taken while busy.
- R2: `spi_cs_n` goes low the cycle after a request is accepted, before the first frame byte is offered. It stays low for all six frame bytes.
- R3: Frame byte 0 is `{2'b01, index}`. Frame bytes 1 to 4 are the argument, most significant byte first.
- R4: Frame byte 5 is the check byte. It is 0x87 when the index is 8 and 0x95 for every other index.
- R5: After the frame, every byte sent is 0xFF. The first received byte with bit 7 clear is returned as `rsp_r1`, and polling stops there.
- R6: If POLL_LIMIT poll bytes in a row come back with bit 7 set, the engine reports `rsp_timeout`=1 with `rsp_r1`=0xFF and `rsp_trail`=0. No further bytes are read; it releases chip select and goes on to the idle byte.
- R7: For index 8 and index 58, four more 0xFF bytes are exchanged after the status byte, with chip select still low. The first of these received bytes lands in `rsp_trail[31:24]`. Any other index gives `rsp_trail`=0 and reads no extra bytes.
- R8: Without hold, or on a timeout, `spi_cs_n` goes high after the last response byte. Exactly one 0xFF byte is then exchanged with chip select high before `rsp_valid` rises.
- R9: With `req_hold`=1 and no timeout, `spi_cs_n` stays low through and after the response, and no idle byte is sent. A timeout overrides hold.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_r1`, `rsp_trail` and `rsp_timeout` stay stable.
- R11: While `spi_tx_valid` is high and `spi_tx_ready` is low, `spi_tx_valid` stays high and `spi_tx_data` stays stable. Each offered byte is sent exactly once.
- R12: After reset, `spi_cs_n`=1, `busy`=0, `req_ready`=1, `spi_tx_valid`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_idx | input | 6 | Command index |
| req_arg | input | ARG_W | Command argument |
| req_hold | input | 1 | Keep chip select low after the response |
| busy | output | 1 | Exchange in progress |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result taken |
| rsp_r1 | output | 8 | Status byte, 0xFF on timeout |
| rsp_trail | output | 8*TRAIL_BYTES | Trailing answer bytes, first byte in the top bits |
| rsp_timeout | output | 1 | No status byte within POLL_LIMIT polls |
| spi_cs_n | output | 1 | Card chip select, active low |
| spi_tx_valid | output | 1 | Byte offered to the SPI master |
| spi_tx_ready | input | 1 | SPI master accepts the byte |
| spi_tx_data | output | 8 | Byte to shift out |
| spi_rx_valid | input | 1 | Received byte strobe |
| spi_rx_data | input | 8 | Byte shifted in |

## Verification
The bench builds the engine with the default 32-bit argument and four trailing bytes, and lowers POLL_LIMIT to 8. This puts the timeout path, and the exact count of poll bytes before it, within a few dozen cycles. The card model stalls the transmit handshake every third cycle, so the offer-hold rule is exercised on nearly every byte. Scripted answers cover a status byte after several busy polls, a status byte on the first poll, both trailer commands, a held chip select followed by a normal command, and a timeout with hold requested.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_POLL,
    ST_TRAIL,
    ST_RELEASE,
    ST_RESULT
  } eng_state_t;

  typedef enum logic [1:0] {
    XS_IDLE,
    XS_OFFER,
    XS_WAIT
  } xchg_state_t;

  localparam logic [7:0] FILL_BYTE   = 8'hFF;
  localparam logic [7:0] CHECK_DEF   = 8'h95;
  localparam logic [7:0] CHECK_IFC   = 8'h87;
  localparam logic [5:0] IDX_IFC     = 6'd8;
  localparam logic [5:0] IDX_OCR     = 6'd58;
  localparam logic [1:0] START_BITS  = 2'b01;

  function automatic logic [7:0] check_for(input logic [5:0] idx);
    return (idx == IDX_IFC) ? CHECK_IFC : CHECK_DEF;
  endfunction

  function automatic logic wants_trailer(input logic [5:0] idx);
    return (idx == IDX_IFC) || (idx == IDX_OCR);
  endfunction

endpackage

// File: rtl/sdcmd_framer.sv
module sdcmd_framer
  import sdcmd_pkg::*;
#(
  parameter int ARG_W = 32,
  parameter int SEL_W = 3
) (
  input  logic [5:0]       idx,
  input  logic [ARG_W-1:0] arg,
  input  logic [SEL_W-1:0] sel,
  output logic [7:0]       frame_byte
);
  localparam int ARG_BYTES   = ARG_W / 8;
  localparam int FRAME_BYTES = ARG_BYTES + 2;

  logic [7:0] frame [FRAME_BYTES];

  assign frame[0] = {START_BITS, idx};

  for (genvar g = 0; g < ARG_BYTES; g++) begin : g_arg
    assign frame[g + 1] = arg[ARG_W - 1 - 8 * g -: 8];
  end

  assign frame[FRAME_BYTES - 1] = check_for(idx);

  always_comb begin
    frame_byte = FILL_BYTE;
    for (int i = 0; i < FRAME_BYTES; i++) begin
      if (sel == SEL_W'(i)) frame_byte = frame[i];
    end
  end

endmodule

// File: rtl/sdcmd_poll_limit.sv
module sdcmd_poll_limit #(
  parameter int LIMIT = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (step && !last) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(LIMIT - 1));

  // R6: the count of failed polls never passes the limit
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LIMIT));

endmodule

// File: rtl/sdcmd_xchg.sv
module sdcmd_xchg
  import sdcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       idle,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       spi_tx_valid,
  input  logic       spi_tx_ready,
  output logic [7:0] spi_tx_data,
  input  logic       spi_rx_valid,
  input  logic [7:0] spi_rx_data
);
  xchg_state_t xs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs          <= XS_IDLE;
      spi_tx_data <= FILL_BYTE;
      rx_byte     <= FILL_BYTE;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (xs)
        XS_IDLE: if (start) begin
          spi_tx_data <= tx_byte;
          xs          <= XS_OFFER;
        end
        XS_OFFER: if (spi_tx_ready) xs <= XS_WAIT;
        XS_WAIT: if (spi_rx_valid) begin
          rx_byte <= spi_rx_data;
          done    <= 1'b1;
          xs      <= XS_IDLE;
        end
        default: xs <= XS_IDLE;
      endcase
    end
  end

  assign spi_tx_valid = (xs == XS_OFFER);
  assign idle         = (xs == XS_IDLE);

  // R11: an offered byte is held until the master takes it
  a_r11_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_valid && !spi_tx_ready |=> spi_tx_valid && $stable(spi_tx_data));

  // R11: a new byte is never started over a pending one
  a_r11_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> xs == XS_IDLE);

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int ARG_W       = 32,
  parameter int POLL_LIMIT  = 5000,
  parameter int TRAIL_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [5:0]               req_idx,
  input  logic [ARG_W-1:0]         req_arg,
  input  logic                     req_hold,
  output logic                     busy,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [7:0]               rsp_r1,
  output logic [8*TRAIL_BYTES-1:0] rsp_trail,
  output logic                     rsp_timeout,
  output logic                     spi_cs_n,
  output logic                     spi_tx_valid,
  input  logic                     spi_tx_ready,
  output logic [7:0]               spi_tx_data,
  input  logic                     spi_rx_valid,
  input  logic [7:0]               spi_rx_data
);
  localparam int FRAME_BYTES = ARG_W / 8 + 2;
  localparam int CNT_MAX     = (FRAME_BYTES > TRAIL_BYTES) ? FRAME_BYTES : TRAIL_BYTES;
  localparam int CNT_W       = $clog2(CNT_MAX + 1);
  localparam int TW          = 8 * TRAIL_BYTES;

  eng_state_t         state;
  logic [5:0]         idx_q;
  logic [ARG_W-1:0]   arg_q;
  logic               hold_q;
  logic               trail_q;
  logic [CNT_W-1:0]   cnt;
  logic [7:0]         r1_q;
  logic [TW-1:0]      trail_data;
  logic               tmo_q;
  logic               cs_n_q;

  logic               xg_start;
  logic               xg_idle;
  logic               xg_done;
  logic [7:0]         xg_rx;
  logic [7:0]         frame_byte;
  logic [7:0]         tx_byte;
  logic               poll_step;
  logic               poll_last;
  logic               active;

  assign active   = (state == ST_SEND) || (state == ST_POLL) ||
                    (state == ST_TRAIL) || (state == ST_RELEASE);
  assign xg_start = active && xg_idle && !xg_done;
  assign tx_byte  = (state == ST_SEND) ? frame_byte : FILL_BYTE;
  assign poll_step = (state == ST_POLL) && xg_done && xg_rx[7];

  sdcmd_framer #(.ARG_W(ARG_W), .SEL_W(CNT_W)) u_framer (
    .idx        (idx_q),
    .arg        (arg_q),
    .sel        (cnt),
    .frame_byte (frame_byte)
  );

  sdcmd_poll_limit #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state == ST_SEND),
    .step  (poll_step),
    .last  (poll_last)
  );

  sdcmd_xchg u_xchg (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (xg_start),
    .tx_byte      (tx_byte),
    .idle         (xg_idle),
    .done         (xg_done),
    .rx_byte      (xg_rx),
    .spi_tx_valid (spi_tx_valid),
    .spi_tx_ready (spi_tx_ready),
    .spi_tx_data  (spi_tx_data),
    .spi_rx_valid (spi_rx_valid),
    .spi_rx_data  (spi_rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      idx_q      <= '0;
      arg_q      <= '0;
      hold_q     <= 1'b0;
      trail_q    <= 1'b0;
      cnt        <= '0;
      r1_q       <= FILL_BYTE;
      trail_data <= '0;
      tmo_q      <= 1'b0;
      cs_n_q     <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          idx_q      <= req_idx;
          arg_q      <= req_arg;
          hold_q     <= req_hold;
          trail_q    <= wants_trailer(req_idx);
          cnt        <= '0;
          r1_q       <= FILL_BYTE;
          trail_data <= '0;
          tmo_q      <= 1'b0;
          cs_n_q     <= 1'b0;
          state      <= ST_SEND;
        end
        ST_SEND: if (xg_done) begin
          if (cnt == CNT_W'(FRAME_BYTES - 1)) begin
            cnt   <= '0;
            state <= ST_POLL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_POLL: if (xg_done) begin
          if (!xg_rx[7]) begin
            r1_q <= xg_rx;
            if (trail_q) begin
              cnt   <= '0;
              state <= ST_TRAIL;
            end else if (hold_q) begin
              state <= ST_RESULT;
            end else begin
              cs_n_q <= 1'b1;
              state  <= ST_RELEASE;
            end
          end else if (poll_last) begin
            r1_q   <= FILL_BYTE;
            tmo_q  <= 1'b1;
            cs_n_q <= 1'b1;
            state  <= ST_RELEASE;
          end
        end
        ST_TRAIL: if (xg_done) begin
          trail_data <= {trail_data[TW-9:0], xg_rx};
          if (cnt == CNT_W'(TRAIL_BYTES - 1)) begin
            if (hold_q) begin
              state <= ST_RESULT;
            end else begin
              cs_n_q <= 1'b1;
              state  <= ST_RELEASE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RELEASE: if (xg_done) state <= ST_RESULT;
        ST_RESULT: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == ST_IDLE);
  assign busy        = (state != ST_IDLE);
  assign rsp_valid   = (state == ST_RESULT);
  assign rsp_r1      = r1_q;
  assign rsp_trail   = trail_data;
  assign rsp_timeout = tmo_q;
  assign spi_cs_n    = cs_n_q;

  // R1: once busy, the engine stays busy until the result is taken
  a_r1_busy_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(rsp_valid && rsp_ready) |=> busy);

  // R1: an accepted request raises busy on the next cycle
  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready);

  // R2: frame bytes only go out with chip select low
  a_r2_cs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_valid && state == ST_SEND |-> !spi_cs_n);

  // R8: the idle byte goes out with chip select high
  a_r8_release_cs: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_valid && state == ST_RELEASE |-> spi_cs_n && spi_tx_data == FILL_BYTE);

  // R5: a reported status byte always has its top bit clear
  a_r5_status_msb: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_timeout |-> !rsp_r1[7]);

  // R6: a timeout reports all ones, no trailer, bus released
  a_r6_timeout_fields: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_timeout |-> rsp_r1 == 8'hFF && rsp_trail == '0 && spi_cs_n);

  // R9: a held, successful exchange keeps chip select low
  a_r9_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && hold_q && !rsp_timeout |-> !spi_cs_n);

  // R10: the result stays put until taken
  a_r10_rsp_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_r1) &&
                               $stable(rsp_trail) && $stable(rsp_timeout));

endmodule

// File: tb/sdcmd_engine_test.sv
module sdcmd_engine_test;
  localparam int PL = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_idx = '0;
  logic [31:0] req_arg = '0;
  logic        req_hold = 1'b0;
  logic        busy;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [7:0]  rsp_r1;
  logic [31:0] rsp_trail;
  logic        rsp_timeout;
  logic        spi_cs_n;
  logic        spi_tx_valid;
  logic        spi_tx_ready = 1'b0;
  logic [7:0]  spi_tx_data;
  logic        spi_rx_valid = 1'b0;
  logic [7:0]  spi_rx_data = 8'hFF;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  sdcmd_engine #(.ARG_W(32), .POLL_LIMIT(PL), .TRAIL_BYTES(4)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx),
    .req_arg(req_arg), .req_hold(req_hold), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_r1(rsp_r1),
    .rsp_trail(rsp_trail), .rsp_timeout(rsp_timeout),
    .spi_cs_n(spi_cs_n), .spi_tx_valid(spi_tx_valid),
    .spi_tx_ready(spi_tx_ready), .spi_tx_data(spi_tx_data),
    .spi_rx_valid(spi_rx_valid), .spi_rx_data(spi_rx_data)
  );

  // card model: logs every accepted byte, answers one byte per handshake
  logic [7:0] tx_log [512];
  logic       cs_log [512];
  int hs_count = 0;
  int served = 0;
  int base = 0;
  logic [7:0] script [16];
  int script_n = 0;
  int stall = 0;

  always @(posedge clk) begin
    if (spi_tx_valid && spi_tx_ready) begin
      tx_log[hs_count % 512] <= spi_tx_data;
      cs_log[hs_count % 512] <= spi_cs_n;
      hs_count <= hs_count + 1;
    end
  end

  always @(negedge clk) begin
    int k;
    stall = stall + 1;
    spi_tx_ready = (stall % 3) != 0;
    spi_rx_valid = 1'b0;
    if (served != hs_count) begin
      k = served - base - 6;
      spi_rx_data = (k >= 0 && k < script_n) ? script[k] : 8'hFF;
      spi_rx_valid = 1'b1;
      served = served + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic hold,
                         output logic [7:0] r1, output logic [31:0] tr,
                         output logic tmo, output int nx);
    @(negedge clk);
    base = hs_count;
    req_idx = idx; req_arg = arg; req_hold = hold; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 busy after accept", {31'd0, busy}, 32'd1);
    chk("R1 ready low while busy", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b1; req_idx = 6'd33;   // must be ignored while busy
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    r1 = rsp_r1; tr = rsp_trail; tmo = rsp_timeout;
    repeat (2) @(negedge clk);
    chk("R10 valid held", {31'd0, rsp_valid}, 32'd1);
    chk("R10 r1 stable", {24'd0, rsp_r1}, {24'd0, r1});
    chk("R10 trail stable", rsp_trail, tr);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    @(negedge clk);
    chk("R1 ready after result", {31'd0, req_ready}, 32'd1);
    nx = hs_count - base;
  endtask

  task automatic check_frame(input logic [5:0] idx, input logic [31:0] arg);
    chk("R3 start byte", {24'd0, tx_log[base % 512]}, {24'd0, 2'b01, idx});
    for (int i = 0; i < 4; i++)
      chk("R3 arg byte", {24'd0, tx_log[(base + 1 + i) % 512]}, {24'd0, arg[31 - 8*i -: 8]});
    chk("R4 check byte", {24'd0, tx_log[(base + 5) % 512]},
        (idx == 6'd8) ? 32'h87 : 32'h95);
    for (int i = 0; i < 6; i++)
      chk("R2 cs low on frame", {31'd0, cs_log[(base + i) % 512]}, 32'd0);
  endtask

  task automatic check_tail(input int nx, input logic released);
    for (int i = 6; i < nx; i++) begin
      chk("R5 fill byte", {24'd0, tx_log[(base + i) % 512]}, 32'hFF);
      if (i < nx - 1 || !released)
        chk("R7 cs low while reading", {31'd0, cs_log[(base + i) % 512]}, 32'd0);
    end
    if (released)
      chk("R8 idle byte with cs high", {31'd0, cs_log[(base + nx - 1) % 512]}, 32'd1);
  endtask

  task automatic t_reset;
    chk("R12 cs_n", {31'd0, spi_cs_n}, 32'd1);
    chk("R12 busy", {31'd0, busy}, 32'd0);
    chk("R12 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R12 tx_valid", {31'd0, spi_tx_valid}, 32'd0);
    chk("R12 rsp_valid", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_go_idle;
    logic [7:0] r1; logic [31:0] tr; logic tmo; int nx;
    script[0] = 8'hFF; script[1] = 8'hFF; script[2] = 8'h01; script_n = 3;
    run_cmd(6'd0, 32'h0, 1'b0, r1, tr, tmo, nx);
    chk("R5 status after busy polls", {24'd0, r1}, 32'h01);
    chk("R5 no timeout", {31'd0, tmo}, 32'd0);
    chk("R7 no trailer", tr, 32'd0);
    chk("R8 exchange count", nx, 10);
    chk("R8 cs high after", {31'd0, spi_cs_n}, 32'd1);
    check_frame(6'd0, 32'h0);
    check_tail(nx, 1'b1);
  endtask

  task automatic t_ifcond;
    logic [7:0] r1; logic [31:0] tr; logic tmo; int nx;
    script[0] = 8'h01; script[1] = 8'h00; script[2] = 8'h00;
    script[3] = 8'h01; script[4] = 8'hAA; script_n = 5;
    run_cmd(6'd8, 32'h000001AA, 1'b0, r1, tr, tmo, nx);
    chk("R7 r1", {24'd0, r1}, 32'h01);
    chk("R7 trailer index 8", tr, 32'h000001AA);
    chk("R7 exchange count", nx, 12);
    check_frame(6'd8, 32'h000001AA);
    check_tail(nx, 1'b1);
  endtask

  task automatic t_hold_then_ocr;
    logic [7:0] r1; logic [31:0] tr; logic tmo; int nx;
    script[0] = 8'hFF; script[1] = 8'h00; script_n = 2;
    run_cmd(6'd17, 32'h12345678, 1'b1, r1, tr, tmo, nx);
    chk("R9 r1", {24'd0, r1}, 32'h00);
    chk("R9 no idle byte", nx, 8);
    chk("R9 cs held low", {31'd0, spi_cs_n}, 32'd0);
    repeat (4) @(negedge clk);
    chk("R9 bus quiet while held", hs_count - base, 8);
    check_frame(6'd17, 32'h12345678);
    check_tail(nx, 1'b0);
    script[0] = 8'h00; script[1] = 8'hC0; script[2] = 8'hFF;
    script[3] = 8'h80; script[4] = 8'h00; script_n = 5;
    run_cmd(6'd58, 32'h0, 1'b0, r1, tr, tmo, nx);
    chk("R7 trailer index 58", tr, 32'hC0FF8000);
    chk("R7 r1 index 58", {24'd0, r1}, 32'h00);
    chk("R8 cs released", {31'd0, spi_cs_n}, 32'd1);
    chk("R8 exchange count 58", nx, 12);
    check_frame(6'd58, 32'h0);
  endtask

  task automatic t_no_trailer;
    logic [7:0] r1; logic [31:0] tr; logic tmo; int nx;
    script[0] = 8'h05; script[1] = 8'hAA; script_n = 2;
    run_cmd(6'd55, 32'hDEADBEEF, 1'b0, r1, tr, tmo, nx);
    chk("R5 first clear byte wins", {24'd0, r1}, 32'h05);
    chk("R7 no trailer other index", tr, 32'd0);
    chk("R7 no extra bytes", nx, 8);
    check_frame(6'd55, 32'hDEADBEEF);
  endtask

  task automatic t_timeout;
    logic [7:0] r1; logic [31:0] tr; logic tmo; int nx;
    script_n = 0;
    run_cmd(6'd8, 32'h000001AA, 1'b1, r1, tr, tmo, nx);
    chk("R6 timeout flag", {31'd0, tmo}, 32'd1);
    chk("R6 status all ones", {24'd0, r1}, 32'hFF);
    chk("R6 no trailer", tr, 32'd0);
    chk("R6 poll count plus idle byte", nx, 6 + PL + 1);
    chk("R9 timeout overrides hold", {31'd0, spi_cs_n}, 32'd1);
    check_tail(nx, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_go_idle();
    t_ifcond();
    t_hold_then_ocr();
    t_no_trailer();
    t_timeout();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule